// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Execution Unit

This unit executes the four reservation-based atomic instructions of a 64-bit RISC-V core: load-reserved and store-conditional, each in word and doubleword form. The core hands it a decoded instruction (funct5, funct3 and the rs2 field), the rs1 address and the rs2 data. One cycle later the unit returns either a completion pulse with the rd writeback value or an exception with its cause and trap value. The unit drives the memory request itself. The memory is a 64-bit synchronous RAM that returns read data in the cycle after the request.

The unit holds a single reservation, made of a valid flag and a granule number. A granule is a block of `GRAN_BYTES` bytes counted from `RAM_BASE`. A successful load-reserved records the reservation. Every store-conditional that completes clears it. A write by another agent, reported on the snoop port, clears it when it lands in the reserved granule. A store-conditional with no valid reservation fails at once and skips the address checks. A store-conditional to a different granule also fails and raises no fault.

The core must not present a new request until the previous one has produced its completion pulse or its exception.

Top module: `lrsc_unit`

## Requirements
- R1: Decoding uses funct5 and funct3. funct5=00010 selects load-reserved and funct5=00011 selects store-conditional. funct3=010 selects word width and funct3=011 selects doubleword width. Any other pair raises cause 2 (illegal instruction) with trap value 0. An illegal request makes no memory request and leaves the reservation unchanged.
- R2: A load-reserved whose rs2 field is nonzero raises cause 2 with trap value 0.
- R3: Each accepted request produces exactly one of `done_o` and `exc_valid_o`, one cycle after `req_valid_i`. The two are never high together. No exception comes with a completion pulse.
- R4: A load-reserved always clears the existing reservation first. If its address is not a multiple of 4 (word) or 8 (doubleword), it raises cause 4 with the address as trap value.
- R5: An address below `RAM_BASE` raises cause 5 for a load-reserved. For a store-conditional that holds a valid reservation and is aligned, it raises cause 7. The trap value is the address, and no memory request is made.
- R6: A word load-reserved returns the 32-bit half selected by address bit 2 (bit 2 = 1 selects bits 63:32), sign-extended to 64 bits. A doubleword load-reserved returns all 64 bits.
- R7: A successful load-reserved records a valid reservation for granule (address − `RAM_BASE`) / `GRAN_BYTES`.
- R8: A store-conditional with no valid reservation writes rd=1. It makes no alignment or range check, raises no exception and makes no store.
- R9: A store-conditional with a valid reservation and a misaligned address raises cause 6 and keeps the reservation. The same holds for the range fault of R5.
- R10: A store-conditional that is aligned and in range but aimed at a granule other than the reserved one writes rd=1, makes no store and clears the reservation.
- R11: A store-conditional to the reserved granule makes the store and writes rd=0. SC.W writes the low 32 bits of rs2 into the half selected by address bit 2, with byte enables 0x0F or 0xF0. SC.D writes all 64 bits with enables 0xFF. The reservation is then cleared.
- R12: A snoop write into the reserved granule clears the reservation. If it arrives in the same cycle as a store-conditional, that store-conditional fails. If it arrives in the same cycle as a load-reserved to the same granule, the reservation is not set. Snoop addresses below `RAM_BASE` are ignored.
- R13: A memory request is made only in the cycle of an accepted request. The address has its low 3 bits cleared, and the write flag is set only for a succeeding store-conditional.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Instruction presented this cycle |
| funct5_i | input | 5 | funct5 field |
| funct3_i | input | 3 | funct3 field |
| rs2_field_i | input | 5 | rs2 register field |
| rs1_addr_i | input | 64 | Effective address |
| rs2_data_i | input | 64 | Store data |
| mem_req_o | output | 1 | Memory access this cycle |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 64 | Doubleword-aligned address |
| mem_be_o | output | 8 | Byte enables |
| mem_wdata_o | output | 64 | Write data |
| mem_rdata_i | input | 64 | Read data, valid one cycle after a read |
| snoop_valid_i | input | 1 | Write by another agent |
| snoop_addr_i | input | 64 | Address of that write |
| done_o | output | 1 | Instruction completed |
| rd_data_o | output | 64 | rd writeback value, valid with done_o |
| exc_valid_o | output | 1 | Exception raised |
| exc_cause_o | output | 5 | Exception cause code |
| exc_tval_o | output | 64 | Trap value |

## Verification
The assertions check, on every cycle, that a completion pulse and an exception never coincide and that each request yields one of them in the next cycle. They also check that memory requests only accompany a request and never target space below the base, that a store always returns rd=0, and that the trap values fit their causes. Only the bench's scenarios can show how the reservation behaves across a sequence of instructions and snoops, the check order that skips faults when no reservation is held, the sign extension of the selected half, and the exact bytes that a store-conditional leaves in memory.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;

  localparam logic [4:0] F5_LR = 5'b00010;
  localparam logic [4:0] F5_SC = 5'b00011;
  localparam logic [2:0] F3_W  = 3'b010;
  localparam logic [2:0] F3_D  = 3'b011;

  typedef enum logic [4:0] {
    EXC_ILLEGAL  = 5'd2,
    EXC_LD_MISAL = 5'd4,
    EXC_LD_FAULT = 5'd5,
    EXC_ST_MISAL = 5'd6,
    EXC_ST_FAULT = 5'd7
  } exc_cause_e;

  typedef enum logic [1:0] {
    OP_ILL = 2'd0,
    OP_LR  = 2'd1,
    OP_SC  = 2'd2
  } op_e;

endpackage

// File: rtl/lrsc_decode.sv
module lrsc_decode
  import lrsc_pkg::*;
(
  input  logic [4:0] funct5_i,
  input  logic [2:0] funct3_i,
  input  logic [4:0] rs2_field_i,
  output op_e        op_o,
  output logic       dword_o
);

  logic width_ok;

  assign width_ok = (funct3_i == F3_W) || (funct3_i == F3_D);
  assign dword_o  = (funct3_i == F3_D);

  always_comb begin
    op_o = OP_ILL;
    if (width_ok) begin
      if (funct5_i == F5_LR && rs2_field_i == 5'd0) op_o = OP_LR;
      else if (funct5_i == F5_SC)                   op_o = OP_SC;
    end
  end

endmodule

// File: rtl/lrsc_granule.sv
module lrsc_granule #(
  parameter logic [63:0] RAM_BASE   = 64'h8000_0000,
  parameter int unsigned GRAN_BYTES = 8,
  localparam int unsigned GRAN_LG   = $clog2(GRAN_BYTES),
  localparam int unsigned GW        = 64 - GRAN_LG
) (
  input  logic [63:0]   addr_i,
  output logic          below_o,
  output logic [GW-1:0] gran_o
);

  logic [63:0] offs;

  assign below_o = addr_i < RAM_BASE;
  assign offs    = addr_i - RAM_BASE;
  assign gran_o  = GW'(offs >> GRAN_LG);

endmodule

// File: rtl/lrsc_resv.sv
module lrsc_resv #(
  parameter int unsigned GW = 61
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          set_i,
  input  logic [GW-1:0] set_gran_i,
  input  logic          clr_i,
  input  logic          snoop_valid_i,
  input  logic [GW-1:0] snoop_gran_i,
  output logic          valid_o,
  output logic [GW-1:0] gran_o
);

  logic          valid_q;
  logic [GW-1:0] gran_q;
  logic          snoop_hit;
  logic          snoop_on_set;

  assign snoop_hit    = snoop_valid_i && valid_q && (snoop_gran_i == gran_q);
  assign snoop_on_set = snoop_valid_i && (snoop_gran_i == set_gran_i);
  // a snoop in the same cycle already kills the reservation seen by an SC
  assign valid_o      = valid_q && !snoop_hit;
  assign gran_o       = gran_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      gran_q  <= '0;
    end else if (set_i) begin
      valid_q <= !snoop_on_set;
      gran_q  <= set_gran_i;
    end else if (clr_i || snoop_hit) begin
      valid_q <= 1'b0;
    end
  end

endmodule

// File: rtl/lrsc_unit.sv
module lrsc_unit
  import lrsc_pkg::*;
#(
  parameter logic [63:0] RAM_BASE   = 64'h8000_0000,
  parameter int unsigned GRAN_BYTES = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  input  logic [4:0]  funct5_i,
  input  logic [2:0]  funct3_i,
  input  logic [4:0]  rs2_field_i,
  input  logic [63:0] rs1_addr_i,
  input  logic [63:0] rs2_data_i,
  output logic        mem_req_o,
  output logic        mem_we_o,
  output logic [63:0] mem_addr_o,
  output logic [7:0]  mem_be_o,
  output logic [63:0] mem_wdata_o,
  input  logic [63:0] mem_rdata_i,
  input  logic        snoop_valid_i,
  input  logic [63:0] snoop_addr_i,
  output logic        done_o,
  output logic [63:0] rd_data_o,
  output logic        exc_valid_o,
  output logic [4:0]  exc_cause_o,
  output logic [63:0] exc_tval_o
);

  localparam int unsigned GRAN_LG = $clog2(GRAN_BYTES);
  localparam int unsigned GW      = 64 - GRAN_LG;
  localparam int unsigned LANES   = 2;

  op_e           op;
  logic          dword;
  logic          req_below, snp_below;
  logic [GW-1:0] req_gran, snp_gran, res_gran;
  logic          res_valid;
  logic          misal;

  logic is_lr, is_sc, is_ill;
  logic lr_ok, lr_bad;
  logic sc_nores, sc_chk, sc_bad, sc_pass, sc_hit;
  logic done_d, exc_d;
  exc_cause_e cause_d;

  logic        done_q, exc_q, lr_q, dword_q, hi_q, sc_fail_q;
  exc_cause_e  cause_q;
  logic [63:0] tval_q;
  logic [31:0] half;

  lrsc_decode u_dec (
    .funct5_i    (funct5_i),
    .funct3_i    (funct3_i),
    .rs2_field_i (rs2_field_i),
    .op_o        (op),
    .dword_o     (dword)
  );

  lrsc_granule #(.RAM_BASE(RAM_BASE), .GRAN_BYTES(GRAN_BYTES)) u_gran_req (
    .addr_i  (rs1_addr_i),
    .below_o (req_below),
    .gran_o  (req_gran)
  );

  lrsc_granule #(.RAM_BASE(RAM_BASE), .GRAN_BYTES(GRAN_BYTES)) u_gran_snp (
    .addr_i  (snoop_addr_i),
    .below_o (snp_below),
    .gran_o  (snp_gran)
  );

  assign misal = dword ? (rs1_addr_i[2:0] != 3'd0) : (rs1_addr_i[1:0] != 2'd0);

  assign is_lr  = req_valid_i && (op == OP_LR);
  assign is_sc  = req_valid_i && (op == OP_SC);
  assign is_ill = req_valid_i && (op == OP_ILL);

  assign lr_ok    = is_lr && !misal && !req_below;
  assign lr_bad   = is_lr && (misal || req_below);
  // no reservation: fail before any address check
  assign sc_nores = is_sc && !res_valid;
  assign sc_chk   = is_sc && res_valid;
  assign sc_bad   = sc_chk && (misal || req_below);
  assign sc_pass  = sc_chk && !misal && !req_below;
  assign sc_hit   = sc_pass && (req_gran == res_gran);

  assign done_d = lr_ok || sc_nores || sc_pass;
  assign exc_d  = is_ill || lr_bad || sc_bad;

  always_comb begin
    cause_d = EXC_ILLEGAL;
    if (is_lr)      cause_d = misal ? EXC_LD_MISAL : EXC_LD_FAULT;
    else if (is_sc) cause_d = misal ? EXC_ST_MISAL : EXC_ST_FAULT;
  end

  lrsc_resv #(.GW(GW)) u_resv (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .set_i         (lr_ok),
    .set_gran_i    (req_gran),
    .clr_i         (lr_bad || sc_nores || sc_pass),
    .snoop_valid_i (snoop_valid_i && !snp_below),
    .snoop_gran_i  (snp_gran),
    .valid_o       (res_valid),
    .gran_o        (res_gran)
  );

  // memory side
  assign mem_req_o  = lr_ok || sc_hit;
  assign mem_we_o   = sc_hit;
  assign mem_addr_o = {rs1_addr_i[63:3], 3'b000};

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign mem_wdata_o[32*l +: 32] = dword ? rs2_data_i[32*l +: 32] : rs2_data_i[31:0];
    assign mem_be_o[4*l +: 4]      = {4{dword || (rs1_addr_i[2] == 1'(l))}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q    <= 1'b0;
      exc_q     <= 1'b0;
      lr_q      <= 1'b0;
      dword_q   <= 1'b0;
      hi_q      <= 1'b0;
      sc_fail_q <= 1'b0;
      cause_q   <= EXC_ILLEGAL;
      tval_q    <= '0;
    end else begin
      done_q    <= done_d;
      exc_q     <= exc_d;
      lr_q      <= is_lr;
      dword_q   <= dword;
      hi_q      <= rs1_addr_i[2];
      sc_fail_q <= !sc_hit;
      if (exc_d) begin
        cause_q <= cause_d;
        tval_q  <= is_ill ? 64'd0 : rs1_addr_i;
      end
    end
  end

  assign half = hi_q ? mem_rdata_i[63:32] : mem_rdata_i[31:0];

  always_comb begin
    rd_data_o = '0;
    if (done_q) begin
      if (lr_q) rd_data_o = dword_q ? mem_rdata_i : {{32{half[31]}}, half};
      else      rd_data_o = {63'd0, sc_fail_q};
    end
  end

  assign done_o      = done_q;
  assign exc_valid_o = exc_q;
  assign exc_cause_o = cause_q;
  assign exc_tval_o  = exc_q ? tval_q : 64'd0;

endmodule

// File: rtl/lrsc_unit_chk.sv
module lrsc_unit_chk #(
  parameter logic [63:0] RAM_BASE   = 64'h8000_0000,
  parameter int unsigned GRAN_BYTES = 8
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic [4:0]  funct5_i,
  input logic [2:0]  funct3_i,
  input logic [4:0]  rs2_field_i,
  input logic [63:0] rs1_addr_i,
  input logic [63:0] rs2_data_i,
  input logic        mem_req_o,
  input logic        mem_we_o,
  input logic [63:0] mem_addr_o,
  input logic [7:0]  mem_be_o,
  input logic [63:0] mem_wdata_o,
  input logic [63:0] mem_rdata_i,
  input logic        snoop_valid_i,
  input logic [63:0] snoop_addr_i,
  input logic        done_o,
  input logic [63:0] rd_data_o,
  input logic        exc_valid_o,
  input logic [4:0]  exc_cause_o,
  input logic [63:0] exc_tval_o
);

  a_r3_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && exc_valid_o));

  a_r3_one_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (done_o || exc_valid_o));

  a_r3_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || exc_valid_o) |-> $past(req_valid_i));

  a_r13_req_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> req_valid_i);

  a_r13_addr_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[2:0] == 3'd0 && mem_addr_o == {rs1_addr_i[63:3], 3'b000}));

  a_r5_no_access_below: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> rs1_addr_i >= RAM_BASE);

  a_r11_store_be: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> (mem_be_o == 8'h0F || mem_be_o == 8'hF0 || mem_be_o == 8'hFF));

  a_r11_store_rd0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |=> (done_o && rd_data_o == 64'd0));

  a_r5_fault_tval: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_valid_o && (exc_cause_o == 5'd5 || exc_cause_o == 5'd7)) |-> exc_tval_o < RAM_BASE);

  a_r4_misal_tval: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_valid_o && (exc_cause_o == 5'd4 || exc_cause_o == 5'd6)) |-> exc_tval_o[2:0] != 3'd0);

  a_r1_illegal_tval: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_valid_o && exc_cause_o == 5'd2) |-> exc_tval_o == 64'd0);

endmodule

bind lrsc_unit lrsc_unit_chk #(.RAM_BASE(RAM_BASE), .GRAN_BYTES(GRAN_BYTES)) u_chk (.*);

// File: tb/lrsc_unit_tb_top.sv
module lrsc_unit_tb_top;

  localparam logic [63:0] BASE = 64'h8000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [4:0]  funct5 = '0;
  logic [2:0]  funct3 = '0;
  logic [4:0]  rs2_field = '0;
  logic [63:0] rs1_addr = '0;
  logic [63:0] rs2_data = '0;
  logic        mem_req, mem_we;
  logic [63:0] mem_addr, mem_wdata;
  logic [7:0]  mem_be;
  logic [63:0] mem_rdata = '0;
  logic        snoop_valid = 1'b0;
  logic [63:0] snoop_addr = '0;
  logic        done, exc_valid;
  logic [63:0] rd_data, exc_tval;
  logic [4:0]  exc_cause;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [63:0] ram [16];
  logic [63:0] exp_mem [16];
  logic        m_res_v = 1'b0;
  logic [60:0] m_res_g = '0;

  always #4 clk = ~clk;

  lrsc_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid),
    .funct5_i(funct5), .funct3_i(funct3), .rs2_field_i(rs2_field),
    .rs1_addr_i(rs1_addr), .rs2_data_i(rs2_data),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_be_o(mem_be), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .snoop_valid_i(snoop_valid), .snoop_addr_i(snoop_addr),
    .done_o(done), .rd_data_o(rd_data), .exc_valid_o(exc_valid),
    .exc_cause_o(exc_cause), .exc_tval_o(exc_tval)
  );

  // synchronous RAM model, one-cycle read latency
  always @(posedge clk) begin
    if (mem_req && mem_addr >= BASE && mem_addr < BASE + 64'd128) begin
      if (mem_we) begin
        for (int b = 0; b < 8; b++)
          if (mem_be[b]) ram[mem_addr[6:3]][8*b +: 8] <= mem_wdata[8*b +: 8];
      end else begin
        mem_rdata <= ram[mem_addr[6:3]];
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [60:0] gran(input logic [63:0] a);
    logic [63:0] o;
    o = a - BASE;
    return o[63:3];
  endfunction

  task automatic run_op(input logic [4:0] f5, input logic [2:0] f3, input logic [4:0] r2f,
                        input logic [63:0] a, input logic [63:0] d,
                        input logic sv, input logic [63:0] sa, input string tag);
    bit is_lr, is_sc, dw, mis, below, e_done, e_exc, e_req, e_we;
    logic [4:0]  e_cause;
    logic [63:0] e_tval, e_rd, w;
    logic [31:0] h;
    is_lr = (f5 == 5'b00010) && (f3 == 3'b010 || f3 == 3'b011) && (r2f == 5'd0);
    is_sc = (f5 == 5'b00011) && (f3 == 3'b010 || f3 == 3'b011);
    dw    = (f3 == 3'b011);
    mis   = dw ? (a[2:0] != 0) : (a[1:0] != 0);
    below = a < BASE;
    e_done = 0; e_exc = 0; e_req = 0; e_we = 0; e_cause = 0; e_tval = 0; e_rd = 0;
    if (sv && sa >= BASE && m_res_v && gran(sa) == m_res_g) m_res_v = 0;
    if (!is_lr && !is_sc) begin
      e_exc = 1; e_cause = 5'd2; e_tval = 0;
    end else if (is_lr) begin
      m_res_v = 0;
      if (mis)        begin e_exc = 1; e_cause = 5'd4; e_tval = a; end
      else if (below) begin e_exc = 1; e_cause = 5'd5; e_tval = a; end
      else begin
        e_done = 1; e_req = 1;
        w = exp_mem[a[6:3]];
        h = a[2] ? w[63:32] : w[31:0];
        e_rd = dw ? w : {{32{h[31]}}, h};
        m_res_g = gran(a);
        m_res_v = !(sv && sa >= BASE && gran(sa) == gran(a));
      end
    end else begin
      if (!m_res_v)   begin e_done = 1; e_rd = 1; end
      else if (mis)   begin e_exc = 1; e_cause = 5'd6; e_tval = a; end
      else if (below) begin e_exc = 1; e_cause = 5'd7; e_tval = a; end
      else if (gran(a) != m_res_g) begin e_done = 1; e_rd = 1; m_res_v = 0; end
      else begin
        e_done = 1; e_rd = 0; e_req = 1; e_we = 1; m_res_v = 0;
        if (dw)        exp_mem[a[6:3]] = d;
        else if (a[2]) exp_mem[a[6:3]][63:32] = d[31:0];
        else           exp_mem[a[6:3]][31:0] = d[31:0];
      end
    end
    @(negedge clk);
    req_valid = 1; funct5 = f5; funct3 = f3; rs2_field = r2f; rs1_addr = a; rs2_data = d;
    snoop_valid = sv; snoop_addr = sa;
    #1;
    chk(mem_req == e_req, "R13 mem_req", 64'(mem_req), 64'(e_req));
    if (e_req) begin
      chk(mem_we == e_we, "R13 mem_we", 64'(mem_we), 64'(e_we));
      chk(mem_addr == {a[63:3], 3'b000}, "R13 mem_addr", mem_addr, {a[63:3], 3'b000});
    end
    @(negedge clk);
    req_valid = 0; snoop_valid = 0;
    #1;
    chk(done == e_done, {tag, " done"}, 64'(done), 64'(e_done));
    chk(exc_valid == e_exc, {tag, " exc"}, 64'(exc_valid), 64'(e_exc));
    chk(!(done && exc_valid), "R3 exclusive", 64'(done), 64'd0);
    if (e_done) chk(rd_data == e_rd, {tag, " rd"}, rd_data, e_rd);
    if (e_exc) begin
      chk(exc_cause == e_cause, {tag, " cause"}, 64'(exc_cause), 64'(e_cause));
      chk(exc_tval == e_tval, {tag, " tval"}, exc_tval, e_tval);
    end
    if (a >= BASE && a < BASE + 64'd128)
      chk(ram[a[6:3]] == exp_mem[a[6:3]], {tag, " memory"}, ram[a[6:3]], exp_mem[a[6:3]]);
  endtask

  task automatic snoop_only(input logic [63:0] sa);
    if (sa >= BASE && m_res_v && gran(sa) == m_res_g) m_res_v = 0;
    @(negedge clk);
    snoop_valid = 1; snoop_addr = sa;
    @(negedge clk);
    snoop_valid = 0;
    chk(!done && !exc_valid, "R12 snoop alone", 64'(done | exc_valid), 64'd0);
  endtask

  localparam logic [4:0] LR = 5'b00010;
  localparam logic [4:0] SC = 5'b00011;
  localparam logic [2:0] W  = 3'b010;
  localparam logic [2:0] D  = 3'b011;

  initial begin
    for (int i = 0; i < 16; i++) begin
      ram[i] = {(i[0] ? 32'hF000_0000 : 32'h0700_0000) | 32'(i),
                (i[1] ? 32'h8ABC_0000 : 32'h1234_0000) | 32'(i * 3)};
      exp_mem[i] = ram[i];
    end
    repeat (3) @(negedge clk);
    chk(!done && !exc_valid && !mem_req, "R3 reset state", 64'(done | exc_valid | mem_req), 64'd0);
    rst_n = 1;
    @(negedge clk);

    // R1: full funct5/funct3 decode sweep
    for (int f5 = 0; f5 < 32; f5++)
      for (int f3 = 0; f3 < 8; f3++)
        run_op(5'(f5), 3'(f3), 5'd0, BASE + 64'd16, 64'h1111_2222_3333_4444, 0, 0, "R1");

    // R2: LR with nonzero rs2 field
    for (int r = 1; r < 32; r++) begin
      run_op(LR, W, 5'(r), BASE + 64'd8, 0, 0, 0, "R2");
      run_op(LR, D, 5'(r), BASE + 64'd8, 0, 0, 0, "R2");
    end

    // R4: alignment sweep for LR; a fault also clears the reservation
    for (int off = 0; off < 8; off++) begin
      run_op(LR, D, 0, BASE + 64'd40, 0, 0, 0, "R7");
      run_op(LR, W, 0, BASE + 64'd32 + 64'(off), 0, 0, 0, "R4");
      run_op(SC, D, 0, BASE + 64'd40, 64'hABCD, 0, 0, "R4 clear");
      run_op(LR, D, 0, BASE + 64'd32 + 64'(off), 0, 0, 0, "R4");
    end

    // R9 / R11: SC alignment sweep with a held reservation
    for (int off = 0; off < 8; off++) begin
      run_op(LR, D, 0, BASE + 64'd48, 0, 0, 0, "R7");
      run_op(SC, D, 0, BASE + 64'd48 + 64'(off), 64'h0123_4567_89AB_CDEF + 64'(off), 0, 0, "R9");
      run_op(SC, W, 0, BASE + 64'd48 + 64'(off), 64'hFEDC_BA98_7654_3210 + 64'(off), 0, 0, "R11");
    end

    // R5: below base
    run_op(LR, W, 0, BASE - 64'd4, 0, 0, 0, "R5");
    run_op(LR, D, 0, BASE - 64'd8, 0, 0, 0, "R5");
    run_op(LR, D, 0, 64'd0, 0, 0, 0, "R5");
    run_op(LR, D, 0, BASE, 0, 0, 0, "R7");
    run_op(SC, D, 0, BASE - 64'd8, 64'h55, 0, 0, "R5");
    run_op(SC, W, 0, BASE - 64'd4, 64'h55, 0, 0, "R5");
    run_op(SC, D, 0, BASE, 64'h5555_AAAA_5555_AAAA, 0, 0, "R11");

    // R8: SC without a reservation skips all checks
    run_op(SC, D, 0, BASE - 64'd3, 64'h77, 0, 0, "R8");
    run_op(SC, W, 0, BASE + 64'd1, 64'h77, 0, 0, "R8");
    run_op(SC, D, 0, BASE + 64'd24, 64'h77, 0, 0, "R8");

    // R6: sign extension of both halves, full doubleword
    for (int i = 0; i < 16; i++) begin
      run_op(LR, W, 0, BASE + 64'(8 * i), 0, 0, 0, "R6");
      run_op(LR, W, 0, BASE + 64'(8 * i + 4), 0, 0, 0, "R6");
      run_op(LR, D, 0, BASE + 64'(8 * i), 0, 0, 0, "R6");
    end

    // R10 / R11: reserve granule i, store to granule j
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++) begin
        run_op(LR, (i[0] ? W : D), 0, BASE + 64'(64 + 8 * i), 0, 0, 0, "R7");
        run_op(SC, (j[0] ? D : W), 0, BASE + 64'(64 + 8 * j + (j[1] ? 4 : 0) * (j[0] ? 0 : 1)),
               64'hC0DE_0000_0000_0000 | 64'(i * 16 + j) | (64'(j) << 36), 0, 0,
               (i == j) ? "R11" : "R10");
        run_op(SC, D, 0, BASE + 64'(64 + 8 * i), 64'hDEAD, 0, 0, "R10 cleared");
      end

    // R12: snoop interaction
    run_op(LR, D, 0, BASE + 64'd88, 0, 0, 0, "R7");
    snoop_only(BASE + 64'd92);
    run_op(SC, D, 0, BASE + 64'd88, 64'h1, 0, 0, "R12 hit");
    run_op(LR, D, 0, BASE + 64'd88, 0, 0, 0, "R7");
    snoop_only(BASE + 64'd96);
    snoop_only(BASE - 64'd8);
    run_op(SC, D, 0, BASE + 64'd88, 64'h2, 0, 0, "R12 miss");
    run_op(LR, W, 0, BASE + 64'd100, 0, 0, 0, "R7");
    run_op(SC, W, 0, BASE + 64'd100, 64'h3, 1, BASE + 64'd96, "R12 same cycle SC");
    run_op(LR, W, 0, BASE + 64'd100, 0, 1, BASE + 64'd96, "R12 same cycle LR");
    run_op(SC, W, 0, BASE + 64'd100, 64'h4, 0, 0, "R12 not set");
    run_op(LR, W, 0, BASE + 64'd100, 0, 1, BASE + 64'd104, "R12 other LR");
    run_op(SC, W, 0, BASE + 64'd100, 64'h5, 0, 0, "R12 set");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule